// File: doc/BRIEF.md
# Funnel Shifter with Fill Word

The block moves an N-bit base word left or right by a run-time amount. The positions that open up are not filled with zeros or sign copies. They are filled with bits from a second fill word, whose width H is set on its own and may be larger or smaller than N. For a left shift, the fill word sits directly below the base word and its upper bits enter the result from the low end. For a right shift, the fill word sits directly above the base word and its lower bits enter the result from the high end.

Each request carries the base word, the fill word, the amount and the direction, and arrives on a valid/ready stream. The shift itself is combinational. One register stage holds the result, which leaves on a second valid/ready stream. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. A result leaves on a rising edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, `out_data` is held unchanged and new requests are refused. When the consumer takes the waiting result, the stage accepts the next request on that same edge. This gives full throughput with no bubble.

Top module: `funnel_shifter`

## Requirements
- R1: With `in_dir` = 0 (left), let C = {base, fill}, which is N+H bits wide with the base in the upper bits. Bit i of the result is C[H - amt + i], for 0 < amt <= H. Example: N=8, H=12, base 8'b10011001, fill 12'b010110100101 and amt 6 give 8'b01010110.
- R2: With `in_dir` = 1 (right), let C = {fill, base}, with the fill in the upper bits. Bit i of the result is C[amt + i], for 0 < amt <= H. With the same operands as in R1, the result is 8'b10010110.
- R3: An amount of 0 returns the base word unchanged in both directions.
- R4: Any amount greater than H gives a result of all zeros in both directions.
- R5: A request accepted on one rising edge has its result on `out_valid`/`out_data` right after that edge. Results leave in the order their requests were accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. `in_ready` equals `!out_valid || out_ready`.
- R7: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can take a request |
| in_base | input | N | Word to be shifted |
| in_fill | input | H | Word that supplies the vacated bits |
| in_amt | input | AW | Unsigned shift amount |
| in_dir | input | 1 | 0 = left, 1 = right |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | N | Shifted result |

## Verification
Every result is due on the first rising edge after its request is accepted. It then remains valid for as long as back-pressure lasts. The bench drives and samples on falling edges. For each request it records the expected value in a queue on the edge where it is accepted. The monitor compares a result only in a cycle where `out_valid` and `out_ready` are both high, so holding the output stage never shifts the expected sequence. A separate check confirms that an output held under back-pressure is still valid and unchanged one cycle later. A directed request confirms the one-edge latency.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic {
    FS_LEFT  = 1'b0,
    FS_RIGHT = 1'b1
  } fs_dir_e;
endpackage

// File: rtl/fs_window.sv
module fs_window #(
  parameter int N  = 8,
  parameter int H  = 12,
  parameter int AW = 4
) (
  input  logic [N-1:0]  base_i,
  input  logic [H-1:0]  fill_i,
  input  logic [AW-1:0] amt_i,
  input  fs_pkg::fs_dir_e dir_i,
  output logic [N-1:0]  res_o
);
  localparam int W = N + H;

  logic [W-1:0] cat_l, cat_r, sh_l, sh_r;
  logic         over;

  assign cat_l = {base_i, fill_i};
  assign cat_r = {fill_i, base_i};
  assign over  = (int'(amt_i) > H);

  // left window: top N bits of the left-shifted concatenation
  assign sh_l = cat_l << amt_i;
  // right window: bottom N bits of the right-shifted concatenation
  assign sh_r = cat_r >> amt_i;

  always_comb begin
    if (over)                          res_o = '0;
    else if (dir_i == fs_pkg::FS_LEFT) res_o = sh_l[W-1 -: N];
    else                               res_o = sh_r[N-1:0];
  end
endmodule

// File: rtl/fs_stage.sv
module fs_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  // R6: a stalled result stays put
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: an accepted request is present on the next cycle
  a_r5_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int N  = 8,
  parameter int H  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_base,
  input  logic [H-1:0]  in_fill,
  input  logic [AW-1:0] in_amt,
  input  logic          in_dir,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N-1:0]  out_data
);
  logic [N-1:0] win;

  fs_window #(.N(N), .H(H), .AW(AW)) u_win (
    .base_i (in_base),
    .fill_i (in_fill),
    .amt_i  (in_amt),
    .dir_i  (fs_pkg::fs_dir_e'(in_dir)),
    .res_o  (win)
  );

  fs_stage #(.DW(N)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (win),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R3: zero amount passes the base word through
  a_r3_zero_amt_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_amt == '0) |=> (out_data == $past(in_base)));

  // R4: amount beyond the fill width clears the result
  a_r4_over_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && int'(in_amt) > H) |=> (out_data == '0));

  // R7: reset empties the output stage
  always_comb begin
    if (!rst_n) a_r7_reset_idle: assert (!out_valid || $isunknown(out_valid));
  end
endmodule

// File: tb/funnel_shifter_tb_top.sv
`timescale 1ns/1ps
module funnel_shifter_tb_top;
  localparam int N  = 8;
  localparam int H  = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_base = '0;
  logic [H-1:0]  in_fill = '0;
  logic [AW-1:0] in_amt = '0;
  logic          in_dir = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [N-1:0]  out_data;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  bit done   = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  funnel_shifter #(.N(N), .H(H), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_fill(in_fill), .in_amt(in_amt), .in_dir(in_dir),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [N-1:0] model(logic [N-1:0] b, logic [H-1:0] h,
                                         int a, bit d);
    logic [N+H-1:0] c;
    logic [N-1:0]   r;
    r = '0;
    if (a > H) return r;
    if (!d) begin
      c = {b, h};
      for (int i = 0; i < N; i++) r[i] = c[H - a + i];
    end else begin
      c = {h, b};
      for (int i = 0; i < N; i++) r[i] = c[a + i];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(logic [N-1:0] b, logic [H-1:0] h, int a, bit d);
    string t;
    @(negedge clk);
    in_valid = 1'b1; in_base = b; in_fill = h; in_amt = AW'(a); in_dir = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (a == 0)      t = "R3";
    else if (a > H)  t = "R4";
    else if (!d)     t = "R1";
    else             t = "R2";
    exp_q.push_back(model(b, h, a, d));
    tag_q.push_back(t);
  endtask

  // monitor: scoreboard pop and back-pressure hold check
  logic         held_pend = 1'b0;
  logic [N-1:0] held_val;
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = bp_en ? ($urandom_range(0, 9) < 6) : 1'b1;
      #1;
      if (held_pend) begin
        check(out_valid && out_data == held_val, "R6", out_data, held_val);
        held_pend = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R5", out_data, '0);
        else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end else if (out_valid && !out_ready) begin
        held_pend = 1'b1;
        held_val  = out_data;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    #1;
    // R7: reset state
    check(out_valid == 1'b0, "R7", N'(out_valid), '0);
    check(in_ready == 1'b1, "R7", N'(in_ready), N'(1));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1/R2 worked example, R5 one-edge latency
    send(8'b10011001, 12'b010110100101, 6, 1'b0);
    @(negedge clk); in_valid = 1'b0; #0.5;
    check(out_valid == 1'b1, "R5", N'(out_valid), N'(1));
    check(out_data == 8'b01010110, "R1", out_data, 8'b01010110);
    send(8'b10011001, 12'b010110100101, 6, 1'b1);
    @(negedge clk); in_valid = 1'b0; #0.5;
    check(out_data == 8'b10010110, "R2", out_data, 8'b10010110);

    // sweep every amount, both directions, under back-pressure
    bp_en = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int rep = 0; rep < 4; rep++)
        for (int a = 0; a < (1 << AW); a++)
          send(N'($urandom), H'($urandom), a, d[0]);
    @(negedge clk); in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule